// File: doc/BRIEF.md
# ADC Result Register Bank

This block keeps the converted values of an analog-to-digital converter in eight 16-bit result registers, named A to H and addressed 0 to 7. Each 10-bit result is stored left-justified, so the top byte of a register carries the eight most significant result bits. A read port returns either the whole register or only that top byte. The registers are read-only from the bus side, and no write path into them exists.

A two-bit buffer mode can turn registers A to D into shift chains. The chains keep a short history of results instead of overwriting the last one. The supported shapes are one two-deep chain, two parallel two-deep chains, or one four-deep chain. A separate sampling bit lets a second result arrive in the same cycle as the first, and both are then stored together.

The buffer mode and the sampling bit take new values only while the converter is halted. Results come in through a simple valid/channel/data interface, with a second channel/data pair that is used only in simultaneous mode.

Top module: `adc_result_bank`

## Requirements
- R1: After a synchronous reset, all eight registers read as zero, the buffer mode output is 2'b00 and the simultaneous-sampling output is 0.
- R2: In buffer mode 2'b00, a result for channel n (0..7) is stored in register n as {result[9:0], 6'b000000}, and no other register changes.
- R3: In buffer mode 2'b01, a channel-0 result is written to A while the old A moves to B. A channel-1 result is dropped. Results for channels 2 to 7 go directly to their own registers.
- R4: In buffer mode 2'b10, a channel-0 result is written to A while the old A moves to C. A channel-1 result is written to B while the old B moves to D. Results for channels 2 and 3 are dropped.
- R5: In buffer mode 2'b11, a channel-0 result shifts the chain: D takes C, C takes B, B takes A, and A takes the result. Results for channels 1 to 3 are dropped.
- R6: Registers E to H (channels 4 to 7) always take their channel's result directly, whatever the buffer mode.
- R7: With simultaneous sampling set, the second channel/data pair is stored in the same cycle as the first. In mode 2'b10, a channel-0/channel-1 pair shifts both chains in that one cycle.
- R8: With simultaneous sampling clear, the second channel/data pair has no effect on any register.
- R9: A configuration write issued while conv_active is high is ignored. A write issued while conv_active is low shows on the mode outputs one cycle later.
- R10: A word read (rd_byte=0) of address n returns all 16 bits of register n on rd_data, one cycle after rd_en.
- R11: A byte read (rd_byte=1) returns {8'h00, result[9:2]}, the top byte of the register, one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_active | input | 1 | High while conversion runs; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_buf_mode | input | 2 | New buffer mode (00 none, 01 A→B, 10 A→C and B→D, 11 A→B→C→D) |
| cfg_dual | input | 1 | New simultaneous-sampling bit |
| buf_mode_q | output | 2 | Current buffer mode |
| dual_q | output | 1 | Current simultaneous-sampling bit |
| res_valid | input | 1 | A result (or pair, in simultaneous mode) is present |
| res_ch | input | 3 | Channel of the first result |
| res_data | input | 10 | First result |
| res_ch2 | input | 3 | Channel of the second result |
| res_data2 | input | 10 | Second result |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Register to read, 0=A .. 7=H |
| rd_byte | input | 1 | 1 = byte read, 0 = word read |
| rd_data | output | 16 | Read data, valid one cycle after rd_en |

## Verification
Two results can be stored in the same clock cycle in simultaneous mode. In mode 2'b10 both chains shift in that cycle, and both shifts must take the values the registers held before the edge. The bench provokes this by driving a channel-0/channel-1 pair twice in a row. It then reads back all four chain registers and expects each first result in its buffer register and each second result in its head register. It also provokes the reverse case: a second pair driven while simultaneous mode is off. There the bench checks through word reads that the register the pair names keeps its earlier value.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;

    typedef enum logic [1:0] {
        BUF_NONE = 2'b00,
        BUF_PAIR = 2'b01,
        BUF_TWIN = 2'b10,
        BUF_QUAD = 2'b11
    } buf_mode_e;

    typedef struct packed {
        buf_mode_e mode;
        logic      dual;
    } bank_cfg_t;

    localparam int CHAIN_LEN = 4;
    localparam int BYTE_W    = 8;

    function automatic logic is_chain_ch(input int ch);
        return ch < CHAIN_LEN;
    endfunction

endpackage

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl
    import adc_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      conv_active,
    input  logic      cfg_we,
    input  logic [1:0] cfg_buf_mode,
    input  logic      cfg_dual,
    output bank_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= BUF_NONE;
            cfg_q.dual <= 1'b0;
        end else if (cfg_we && !conv_active) begin
            cfg_q.mode <= buf_mode_e'(cfg_buf_mode);
            cfg_q.dual <= cfg_dual;
        end
    end

    // R9: a write while converting leaves the configuration untouched
    p_cfg_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && conv_active) |=> $stable(cfg_q))
        else $error("configuration changed while conversion active");

    // R9: a write while halted takes the requested value
    p_cfg_take_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !conv_active) |=> (cfg_q.mode == $past(cfg_buf_mode) && cfg_q.dual == $past(cfg_dual)))
        else $error("configuration write while halted was lost");

endmodule

// File: rtl/adc_write_route.sv
module adc_write_route
    import adc_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int RES_W    = 10,
    parameter int REG_W    = 16,
    localparam int CH_W    = $clog2(NUM_REGS),
    localparam int PAD_W   = REG_W - RES_W
) (
    input  bank_cfg_t              cfg,
    input  logic                   res_valid,
    input  logic [CH_W-1:0]        res_ch,
    input  logic [RES_W-1:0]       res_data,
    input  logic [CH_W-1:0]        res_ch2,
    input  logic [RES_W-1:0]       res_data2,
    input  logic [REG_W-1:0]       chain_q [CHAIN_LEN],
    output logic [NUM_REGS-1:0]    ld,
    output logic [REG_W-1:0]       nxt [NUM_REGS]
);

    always_comb begin
        logic              sv;
        logic [CH_W-1:0]   sc;
        logic [REG_W-1:0]  sval;
        ld = '0;
        for (int i = 0; i < NUM_REGS; i++) nxt[i] = '0;
        // slot 1 (second result of a pair) is applied after slot 0 and wins on a clash
        for (int s = 0; s < 2; s++) begin
            sv   = (s == 0) ? res_valid : (res_valid && cfg.dual);
            sc   = (s == 0) ? res_ch : res_ch2;
            sval = (s == 0) ? {res_data, {PAD_W{1'b0}}} : {res_data2, {PAD_W{1'b0}}};
            if (sv) begin
                if (!is_chain_ch(int'(sc)) || cfg.mode == BUF_NONE) begin
                    ld[sc]  = 1'b1;
                    nxt[sc] = sval;
                end else begin
                    case (cfg.mode)
                        BUF_PAIR: begin
                            if (sc == '0) begin
                                ld[0] = 1'b1; nxt[0] = sval;
                                ld[1] = 1'b1; nxt[1] = chain_q[0];
                            end else if (int'(sc) >= 2) begin
                                ld[sc]  = 1'b1;
                                nxt[sc] = sval;
                            end
                        end
                        BUF_TWIN: begin
                            if (sc == '0) begin
                                ld[0] = 1'b1; nxt[0] = sval;
                                ld[2] = 1'b1; nxt[2] = chain_q[0];
                            end else if (int'(sc) == 1) begin
                                ld[1] = 1'b1; nxt[1] = sval;
                                ld[3] = 1'b1; nxt[3] = chain_q[1];
                            end
                        end
                        BUF_QUAD: begin
                            if (sc == '0) begin
                                ld[0] = 1'b1; nxt[0] = sval;
                                for (int k = 1; k < CHAIN_LEN; k++) begin
                                    ld[k]  = 1'b1;
                                    nxt[k] = chain_q[k-1];
                                end
                            end
                        end
                        default: begin
                            ld[sc]  = 1'b1;
                            nxt[sc] = sval;
                        end
                    endcase
                end
            end
        end
    end

    // R8: with simultaneous sampling off, only the first channel's register may load among E..H
    p_single_slot_r8: assert final (!( !cfg.dual && res_valid && !is_chain_ch(int'(res_ch))
                                       && $countones(ld[NUM_REGS-1:CHAIN_LEN]) > 1))
        else $error("second result loaded with simultaneous sampling off");

endmodule

// File: rtl/adc_read_fmt.sv
module adc_read_fmt
    import adc_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int RES_W    = 10,
    parameter int REG_W    = 16,
    localparam int CH_W    = $clog2(NUM_REGS),
    localparam int PAD_W   = REG_W - RES_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_addr,
    input  logic              rd_byte,
    input  logic [REG_W-1:0]  regs [NUM_REGS],
    output logic [REG_W-1:0]  rd_data
);

    logic [REG_W-1:0] word_sel;

    always_comb word_sel = regs[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_byte)
                rd_data <= {{(REG_W-BYTE_W){1'b0}}, word_sel[REG_W-1 -: BYTE_W]};
            else
                rd_data <= word_sel;
        end
    end

    // R11: a byte read never puts anything in the upper byte
    p_byte_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_byte) |=> (rd_data[REG_W-1:BYTE_W] == '0))
        else $error("byte read left upper bits set");

    // R10: a word read returns a left-justified value (padding bits zero)
    p_word_pad_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_byte) |=> (rd_data[PAD_W-1:0] == '0))
        else $error("word read padding not zero");

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int RES_W    = 10,
    parameter int REG_W    = 16,
    localparam int CH_W    = $clog2(NUM_REGS),
    localparam int PAD_W   = REG_W - RES_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_active,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_buf_mode,
    input  logic              cfg_dual,
    output logic [1:0]        buf_mode_q,
    output logic              dual_q,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [RES_W-1:0]  res_data,
    input  logic [CH_W-1:0]   res_ch2,
    input  logic [RES_W-1:0]  res_data2,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_addr,
    input  logic              rd_byte,
    output logic [REG_W-1:0]  rd_data
);

    bank_cfg_t             cfg;
    logic [REG_W-1:0]      regs    [NUM_REGS];
    logic [REG_W-1:0]      chain_q [CHAIN_LEN];
    logic [REG_W-1:0]      nxt     [NUM_REGS];
    logic [NUM_REGS-1:0]   ld;

    adc_mode_ctrl u_mode (
        .clk          (clk),
        .rst          (rst),
        .conv_active  (conv_active),
        .cfg_we       (cfg_we),
        .cfg_buf_mode (cfg_buf_mode),
        .cfg_dual     (cfg_dual),
        .cfg_q        (cfg)
    );

    assign buf_mode_q = cfg.mode;
    assign dual_q     = cfg.dual;

    generate
        for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_chain_tap
            assign chain_q[c] = regs[c];
        end
    endgenerate

    adc_write_route #(
        .NUM_REGS (NUM_REGS),
        .RES_W    (RES_W),
        .REG_W    (REG_W)
    ) u_route (
        .cfg       (cfg),
        .res_valid (res_valid),
        .res_ch    (res_ch),
        .res_data  (res_data),
        .res_ch2   (res_ch2),
        .res_data2 (res_data2),
        .chain_q   (chain_q),
        .ld        (ld),
        .nxt       (nxt)
    );

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_result_reg
            always_ff @(posedge clk) begin
                if (rst)        regs[r] <= '0;
                else if (ld[r]) regs[r] <= nxt[r];
            end
        end
    endgenerate

    adc_read_fmt #(
        .NUM_REGS (NUM_REGS),
        .RES_W    (RES_W),
        .REG_W    (REG_W)
    ) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte),
        .regs    (regs),
        .rd_data (rd_data)
    );

    // R2: without a result nothing in the bank moves
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> ($stable(regs[0]) && $stable(regs[3]) && $stable(regs[NUM_REGS-1])))
        else $error("register changed with no result");

    // R5: four-deep chain shifts every stage on a channel-0 result
    p_quad_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cfg.mode == BUF_QUAD && res_ch == '0)
        |=> (regs[1] == $past(regs[0]) && regs[2] == $past(regs[1]) && regs[3] == $past(regs[2])))
        else $error("four-deep chain did not shift");

    // R6: register E is loaded directly from channel 4 in every mode
    p_direct_e_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ch == CH_W'(4) && !(cfg.dual && res_ch2 == CH_W'(4)))
        |=> (regs[4] == {$past(res_data), {PAD_W{1'b0}}}))
        else $error("register E not loaded directly");

    // R7: a channel-0/channel-1 pair shifts both twin chains in one cycle
    p_twin_pair_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cfg.dual && cfg.mode == BUF_TWIN && res_ch == '0 && res_ch2 == CH_W'(1))
        |=> (regs[2] == $past(regs[0]) && regs[3] == $past(regs[1])))
        else $error("twin chains did not shift together");

endmodule

// File: tb/sim_adc_result_bank.sv
`timescale 1ns/1ps
module sim_adc_result_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        conv_active, cfg_we, cfg_dual;
    logic [1:0]  cfg_buf_mode, buf_mode_q;
    logic        dual_q;
    logic        res_valid;
    logic [2:0]  res_ch, res_ch2;
    logic [9:0]  res_data, res_data2;
    logic        rd_en, rd_byte;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_result_bank u0 (
        .clk(clk), .rst(rst), .conv_active(conv_active), .cfg_we(cfg_we),
        .cfg_buf_mode(cfg_buf_mode), .cfg_dual(cfg_dual),
        .buf_mode_q(buf_mode_q), .dual_q(dual_q),
        .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
        .res_ch2(res_ch2), .res_data2(res_data2),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_data(rd_data)
    );

    function automatic logic [15:0] wexp(input logic [9:0] d);
        return {d, 6'b000000};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; conv_active = 1'b0; cfg_we = 1'b0; cfg_buf_mode = 2'b00; cfg_dual = 1'b0;
        res_valid = 1'b0; res_ch = '0; res_data = '0; res_ch2 = '0; res_data2 = '0;
        rd_en = 1'b0; rd_addr = '0; rd_byte = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic d, input logic busy);
        @(negedge clk);
        cfg_we = 1'b1; cfg_buf_mode = m; cfg_dual = d; conv_active = busy;
        @(negedge clk);
        cfg_we = 1'b0; conv_active = 1'b0;
    endtask

    task automatic send(input logic [2:0] c, input logic [9:0] d,
                        input logic [2:0] c2, input logic [9:0] d2);
        @(negedge clk);
        res_valid = 1'b1; res_ch = c; res_data = d; res_ch2 = c2; res_data2 = d2;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic b, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; rd_byte = b;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), 1'b0, v);
            chk("R1 register zero after reset", v, 16'h0000);
        end
        chk("R1 buffer mode after reset", {14'b0, buf_mode_q}, 16'h0000);
        chk("R1 dual bit after reset", {15'b0, dual_q}, 16'h0000);
    endtask

    task automatic t_normal();
        logic [15:0] v;
        do_reset();
        set_cfg(2'b00, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send(3'(i), 10'(100 + i * 97), 3'd0, 10'h3FF);
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), 1'b0, v);
            chk("R2/R10 direct word read", v, wexp(10'(100 + i * 97)));
        end
        rd(3'd5, 1'b1, v);
        chk("R11 byte read top bits", v, {8'h00, 8'(10'(100 + 5 * 97) >> 2)});
        rd(3'd7, 1'b1, v);
        chk("R11 byte read channel 7", v, {8'h00, 8'(10'(100 + 7 * 97) >> 2)});
    endtask

    task automatic t_lock();
        do_reset();
        set_cfg(2'b11, 1'b1, 1'b1);
        chk("R9 mode kept while active", {14'b0, buf_mode_q}, 16'h0000);
        chk("R9 dual kept while active", {15'b0, dual_q}, 16'h0000);
        set_cfg(2'b11, 1'b1, 1'b0);
        chk("R9 mode taken while halted", {14'b0, buf_mode_q}, 16'h0003);
        chk("R9 dual taken while halted", {15'b0, dual_q}, 16'h0001);
    endtask

    task automatic t_quad();
        logic [15:0] v;
        do_reset();
        set_cfg(2'b11, 1'b0, 1'b0);
        send(3'd0, 10'h101, 3'd0, 10'h0);
        send(3'd0, 10'h102, 3'd0, 10'h0);
        send(3'd0, 10'h103, 3'd0, 10'h0);
        send(3'd0, 10'h104, 3'd0, 10'h0);
        send(3'd2, 10'h3AA, 3'd0, 10'h0);
        send(3'd4, 10'h155, 3'd0, 10'h0);
        rd(3'd0, 1'b0, v); chk("R5 quad A newest", v, wexp(10'h104));
        rd(3'd1, 1'b0, v); chk("R5 quad B", v, wexp(10'h103));
        rd(3'd2, 1'b0, v); chk("R5 quad C, channel 2 dropped", v, wexp(10'h102));
        rd(3'd3, 1'b0, v); chk("R5 quad D oldest", v, wexp(10'h101));
        rd(3'd4, 1'b0, v); chk("R6 E direct in quad mode", v, wexp(10'h155));
    endtask

    task automatic t_pair();
        logic [15:0] v;
        do_reset();
        set_cfg(2'b01, 1'b0, 1'b0);
        send(3'd0, 10'h0F0, 3'd0, 10'h0);
        send(3'd0, 10'h30F, 3'd0, 10'h0);
        send(3'd1, 10'h111, 3'd0, 10'h0);
        send(3'd3, 10'h222, 3'd0, 10'h0);
        send(3'd7, 10'h2C3, 3'd0, 10'h0);
        rd(3'd0, 1'b0, v); chk("R3 pair A", v, wexp(10'h30F));
        rd(3'd1, 1'b0, v); chk("R3 pair B holds old A, channel 1 dropped", v, wexp(10'h0F0));
        rd(3'd3, 1'b0, v); chk("R3 D direct", v, wexp(10'h222));
        rd(3'd7, 1'b0, v); chk("R6 H direct in pair mode", v, wexp(10'h2C3));
    endtask

    task automatic t_twin();
        logic [15:0] v;
        do_reset();
        set_cfg(2'b10, 1'b1, 1'b0);
        send(3'd0, 10'h011, 3'd1, 10'h022);
        send(3'd0, 10'h033, 3'd1, 10'h044);
        rd(3'd0, 1'b0, v); chk("R7 twin A", v, wexp(10'h033));
        rd(3'd2, 1'b0, v); chk("R7 twin C", v, wexp(10'h011));
        rd(3'd1, 1'b0, v); chk("R7 twin B", v, wexp(10'h044));
        rd(3'd3, 1'b0, v); chk("R7 twin D", v, wexp(10'h022));
        set_cfg(2'b10, 1'b0, 1'b0);
        send(3'd1, 10'h055, 3'd0, 10'h3FF);
        send(3'd2, 10'h066, 3'd0, 10'h0);
        rd(3'd1, 1'b0, v); chk("R4 B takes channel 1", v, wexp(10'h055));
        rd(3'd3, 1'b0, v); chk("R4 D takes old B", v, wexp(10'h044));
        rd(3'd0, 1'b0, v); chk("R8 A untouched by second pair", v, wexp(10'h033));
        rd(3'd2, 1'b0, v); chk("R4 C unchanged, channel 2 dropped", v, wexp(10'h011));
    endtask

    task automatic t_dual_normal();
        logic [15:0] v;
        do_reset();
        set_cfg(2'b00, 1'b1, 1'b0);
        send(3'd2, 10'h123, 3'd6, 10'h2AB);
        rd(3'd2, 1'b0, v); chk("R7 first of pair stored", v, wexp(10'h123));
        rd(3'd6, 1'b0, v); chk("R7 second of pair stored", v, wexp(10'h2AB));
        set_cfg(2'b00, 1'b0, 1'b0);
        send(3'd5, 10'h0AA, 3'd6, 10'h3CC);
        rd(3'd6, 1'b0, v); chk("R8 second result ignored", v, wexp(10'h2AB));
        rd(3'd5, 1'b1, v); chk("R11 byte read after single result", v, {8'h00, 8'h2A});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_lock();
        t_quad();
        t_pair();
        t_twin();
        t_dual_normal();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule